// File: doc/BRIEF.md
# SPD Write-Protection Command Unit

This unit sits beside a serial-presence EEPROM's I2C slave front end. It watches the bytes that the front end has already deserialised and picks out the global protection commands. These commands arrive as the first byte after a START, in place of an ordinary device address. The unit holds one protection bit for each 128-byte block of a 512-byte array. For every received byte it tells the front end whether the byte belongs to it and whether to ACK it.

A status query reports a block's state through the acknowledge of the command byte: ACK means the block is writable and NACK means it is locked. A set command locks one block. A clear command unlocks all four blocks. Set and clear need the high-voltage flag from the address pin while the command byte arrives. They take effect only when STOP follows exactly two dummy bytes. The storage array asks the unit, by byte address, whether a write may proceed.

Top module: `spd_wp_unit`

## Requirements
- R1: After reset the protection mask is 4'b0011: blocks 0 and 1 are locked, blocks 2 and 3 are writable.
- R2: A first byte of 0x63, 0x69, 0x6B or 0x61 queries block 0, 1, 2 or 3 respectively. It is claimed, and ackOut equals the inverse of that block's mask bit.
- R3: A first byte of 0x62, 0x68, 0x6A or 0x60 received with hvPresent high is claimed and ACKed. After two dummy bytes and STOP it sets only mask bit 0, 1, 2 or 3 respectively.
- R4: A first byte of 0x66 received with hvPresent high is claimed and ACKed. After two dummy bytes and STOP it clears all four mask bits.
- R5: A set or clear byte received with hvPresent low is claimed and NACKed, and the mask stays unchanged after the following STOP.
- R6: A set or clear commits only if exactly two non-first bytes came between the command byte and STOP. With one or three dummy bytes the mask is unchanged, and a third dummy byte is NACKed.
- R7: A new first byte (repeated START) before STOP drops a pending set or clear.
- R8: Dummy bytes after a protection command are claimed. They are ACKed only for the first two dummy bytes after an armed set or clear, and NACKed after a query or an unarmed command.
- R9: Any other first byte, and the bytes that follow it, are not claimed, get ackOut low and never change the mask.
- R10: writeAllowed equals the inverse of mask bit wrAddr[8:7], so block k covers byte addresses 128k to 128k+127.
- R11: A committed change is visible on protMask right after the clock edge that samples stopSeen high. ackOut and cmdClaim are low when byteValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe: a byte has been received |
| byteData | input | 8 | Value of the received byte |
| firstByte | input | 1 | The byte is the first after a START or repeated START |
| stopSeen | input | 1 | One-cycle strobe: STOP condition seen |
| hvPresent | input | 1 | High voltage detected on the address-select pin |
| cmdClaim | output | 1 | The current byte belongs to a protection sequence |
| ackOut | output | 1 | 1 = ACK the current byte, 0 = NACK |
| protMask | output | 4 | Protection bit per block, 1 = locked |
| wrAddr | input | 9 | Byte address the array wants to write |
| writeAllowed | output | 1 | The block holding wrAddr is unlocked |

## Verification
The main sweep sends every one of the 256 possible first-byte values, each followed by two dummy bytes and STOP, once with the high-voltage flag low and once with it high. Comparing the claim and acknowledge of each byte with the running mask separates queries, armed and unarmed set/clear, and foreign addresses. Short and long dummy runs, and a repeated START in the middle of a sequence, show that commit depends on the exact framing. A full sweep of all 512 write addresses under several masks pins the block boundaries.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;

  localparam int BLK_W = 2;

  typedef enum logic [1:0] {
    CMD_OTHER = 2'd0,
    CMD_QUERY = 2'd1,
    CMD_SET   = 2'd2,
    CMD_CLEAR = 2'd3
  } cmdKind_e;

  typedef struct packed {
    cmdKind_e         kind;
    logic [BLK_W-1:0] blk;
  } cmdDec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             setStb;
    logic             clrStb;
    logic [BLK_W-1:0] blk;
  } protStrobe_t;

  function automatic cmdDec_t decodeCmd(input logic [7:0] b);
    cmdDec_t d;
    d.kind = CMD_OTHER;
    d.blk  = '0;
    case (b)
      8'h63: begin d.kind = CMD_QUERY; d.blk = 2'd0; end
      8'h69: begin d.kind = CMD_QUERY; d.blk = 2'd1; end
      8'h6B: begin d.kind = CMD_QUERY; d.blk = 2'd2; end
      8'h61: begin d.kind = CMD_QUERY; d.blk = 2'd3; end
      8'h62: begin d.kind = CMD_SET;   d.blk = 2'd0; end
      8'h68: begin d.kind = CMD_SET;   d.blk = 2'd1; end
      8'h6A: begin d.kind = CMD_SET;   d.blk = 2'd2; end
      8'h60: begin d.kind = CMD_SET;   d.blk = 2'd3; end
      8'h66: begin d.kind = CMD_CLEAR; d.blk = 2'd0; end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
  import spd_wp_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int DUMMY_CNT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               firstByte,
  input  logic               stopSeen,
  input  logic               hvPresent,
  input  logic [NUM_BLK-1:0] protMask,
  output logic               cmdClaim,
  output logic               ackOut,
  output protStrobe_t        strobes
);

  localparam int CNT_W = $clog2(DUMMY_CNT + 1);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_QUERY = 2'd1,
    SEQ_ARMED = 2'd2,
    SEQ_DEAD  = 2'd3
  } seq_e;

  seq_e             seqState;
  logic             armedClr;
  logic [BLK_W-1:0] armedBlk;
  logic [CNT_W-1:0] dummyCnt;
  cmdDec_t          dec;
  logic             dummyFull;

  assign dec       = decodeCmd(byteData);
  assign dummyFull = (dummyCnt == CNT_W'(DUMMY_CNT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      armedClr <= 1'b0;
      armedBlk <= '0;
      dummyCnt <= '0;
    end else if (stopSeen) begin
      seqState <= SEQ_IDLE;
      dummyCnt <= '0;
    end else if (byteValid && firstByte) begin
      dummyCnt <= '0;
      armedClr <= (dec.kind == CMD_CLEAR);
      armedBlk <= dec.blk;
      case (dec.kind)
        CMD_QUERY: seqState <= SEQ_QUERY;
        CMD_SET,
        CMD_CLEAR: seqState <= hvPresent ? SEQ_ARMED : SEQ_DEAD;
        default:   seqState <= SEQ_IDLE;
      endcase
    end else if (byteValid && seqState != SEQ_IDLE) begin
      if (dummyFull) seqState <= SEQ_DEAD;
      else           dummyCnt <= dummyCnt + 1'b1;
    end
  end

  always_comb begin
    cmdClaim = 1'b0;
    ackOut   = 1'b0;
    if (byteValid) begin
      if (firstByte) begin
        case (dec.kind)
          CMD_QUERY: begin cmdClaim = 1'b1; ackOut = ~protMask[dec.blk]; end
          CMD_SET,
          CMD_CLEAR: begin cmdClaim = 1'b1; ackOut = hvPresent; end
          default:   ;
        endcase
      end else if (seqState != SEQ_IDLE) begin
        cmdClaim = 1'b1;
        ackOut   = (seqState == SEQ_ARMED) && !dummyFull;
      end
    end
  end

  always_comb begin
    strobes.setStb = stopSeen && seqState == SEQ_ARMED && dummyFull && !armedClr;
    strobes.clrStb = stopSeen && seqState == SEQ_ARMED && dummyFull && armedClr;
    strobes.blk    = armedBlk;
  end

endmodule

// File: rtl/spd_wp_datapath.sv
module spd_wp_datapath
  import spd_wp_pkg::*;
#(
  parameter int                 NUM_BLK      = 4,
  parameter int                 ADDR_W       = 9,
  parameter logic [NUM_BLK-1:0] PROT_DEFAULT = 4'b0011
) (
  input  logic               clk,
  input  logic               rstN,
  input  protStrobe_t        strobes,
  input  logic [ADDR_W-1:0]  wrAddr,
  output logic [NUM_BLK-1:0] protMask,
  output logic               writeAllowed
);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rstN)                                      protMask[g] <= PROT_DEFAULT[g];
      else if (strobes.clrStb)                        protMask[g] <= 1'b0;
      else if (strobes.setStb && strobes.blk == BLK_W'(g)) protMask[g] <= 1'b1;
    end
  end

  logic [BLK_W-1:0] addrBlk;
  assign addrBlk      = wrAddr[ADDR_W-1 -: BLK_W];
  assign writeAllowed = ~protMask[addrBlk];

endmodule

// File: rtl/spd_wp_unit.sv
module spd_wp_unit
  import spd_wp_pkg::*;
#(
  parameter int                 NUM_BLK      = 4,
  parameter int                 ADDR_W       = 9,
  parameter int                 DUMMY_CNT    = 2,
  parameter logic [NUM_BLK-1:0] PROT_DEFAULT = 4'b0011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               firstByte,
  input  logic               stopSeen,
  input  logic               hvPresent,
  output logic               cmdClaim,
  output logic               ackOut,
  output logic [NUM_BLK-1:0] protMask,
  input  logic [ADDR_W-1:0]  wrAddr,
  output logic               writeAllowed
);

  protStrobe_t strobes;

  spd_wp_ctrl #(.NUM_BLK(NUM_BLK), .DUMMY_CNT(DUMMY_CNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .firstByte(firstByte), .stopSeen(stopSeen), .hvPresent(hvPresent),
    .protMask(protMask), .cmdClaim(cmdClaim), .ackOut(ackOut), .strobes(strobes)
  );

  spd_wp_datapath #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .PROT_DEFAULT(PROT_DEFAULT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .protMask(protMask), .writeAllowed(writeAllowed)
  );

endmodule

// File: rtl/spd_wp_chk.sv
module spd_wp_chk #(
  parameter int NUM_BLK = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               byteValid,
  input logic [7:0]         byteData,
  input logic               firstByte,
  input logic               stopSeen,
  input logic               cmdClaim,
  input logic               ackOut,
  input logic [NUM_BLK-1:0] protMask
);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> (!cmdClaim && !ackOut));

  // R9
  ack_needs_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> cmdClaim);

  // R11
  mask_moves_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protMask != $past(protMask)) |-> $past(stopSeen));

  // R3
  mask_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protMask != $past(protMask)) |->
      ((protMask == '0) ||
       ($countones(protMask) == $countones($past(protMask)) + 1)));

  // R2
  query0_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && firstByte && byteData == 8'h63) |-> (cmdClaim && ackOut == !protMask[0]));

endmodule

bind spd_wp_unit spd_wp_chk #(.NUM_BLK(NUM_BLK)) chk_i (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .firstByte(firstByte), .stopSeen(stopSeen), .cmdClaim(cmdClaim),
  .ackOut(ackOut), .protMask(protMask)
);

// File: tb/spd_wp_unit_tb.sv
module spd_wp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       firstByte = 1'b0;
  logic       stopSeen = 1'b0;
  logic       hvPresent = 1'b0;
  logic       cmdClaim, ackOut, writeAllowed;
  logic [3:0] protMask;
  logic [8:0] wrAddr = '0;

  int nChecks = 0;
  int nFails  = 0;

  // bench model
  logic [3:0] mMask;
  int         mSeq;   // 0 idle, 1 query, 2 armed, 3 dead
  int         mCnt;
  int         mKind;  // 0 other 1 query 2 set 3 clear
  int         mBlk;
  int         aKind, aBlk;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_wp_unit dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .firstByte(firstByte), .stopSeen(stopSeen), .hvPresent(hvPresent),
    .cmdClaim(cmdClaim), .ackOut(ackOut), .protMask(protMask),
    .wrAddr(wrAddr), .writeAllowed(writeAllowed)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic classify(input logic [7:0] b, output int kind, output int blk);
    kind = 0; blk = 0;
    case (b)
      8'h63: begin kind = 1; blk = 0; end
      8'h69: begin kind = 1; blk = 1; end
      8'h6B: begin kind = 1; blk = 2; end
      8'h61: begin kind = 1; blk = 3; end
      8'h62: begin kind = 2; blk = 0; end
      8'h68: begin kind = 2; blk = 1; end
      8'h6A: begin kind = 2; blk = 2; end
      8'h60: begin kind = 2; blk = 3; end
      8'h66: begin kind = 3; blk = 0; end
      default: ;
    endcase
  endtask

  // drives one byte, checks claim/ack against the model (R2 R3 R4 R5 R8 R9)
  task automatic sendByte(input logic [7:0] b, input logic f, input logic hv);
    int k, bl, eClaim, eAck;
    @(negedge clk);
    byteValid = 1'b1; byteData = b; firstByte = f; hvPresent = hv;
    #1;
    eClaim = 0; eAck = 0;
    if (f) begin
      classify(b, k, bl);
      if (k == 1) begin eClaim = 1; eAck = !mMask[bl]; end
      else if (k >= 2) begin eClaim = 1; eAck = hv; end
      mKind = k; mBlk = bl; mCnt = 0;
      mSeq = (k == 0) ? 0 : (k == 1) ? 1 : (hv ? 2 : 3);
    end else if (mSeq != 0) begin
      eClaim = 1;
      eAck = (mSeq == 2 && mCnt < 2);
      if (mCnt == 2) mSeq = 3; else mCnt++;
    end
    check("R2/R3/R4/R5/R8/R9 claim", cmdClaim, eClaim);
    check("R2/R3/R4/R5/R8/R9 ack", ackOut, eAck);
    @(posedge clk); #1;
    byteValid = 1'b0; firstByte = 1'b0; hvPresent = 1'b0;
  endtask

  // STOP; commit checked right after the sampling edge (R11)
  task automatic sendStop();
    @(negedge clk);
    stopSeen = 1'b1;
    if (mSeq == 2 && mCnt == 2) begin
      if (mKind == 3) mMask = 4'b0000;
      else            mMask[mBlk] = 1'b1;
    end
    mSeq = 0; mCnt = 0;
    @(posedge clk); #1;
    stopSeen = 1'b0;
    check("R11 mask after STOP", protMask, mMask);
  endtask

  task automatic sweepAddr();
    for (int a = 0; a < 512; a++) begin
      wrAddr = 9'(a);
      #1;
      // R10
      check("R10 writeAllowed", writeAllowed, !mMask[a / 128]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    mMask = 4'b0011; mSeq = 0; mCnt = 0; mKind = 0; mBlk = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset mask", protMask, 4'b0011);
    check("R11 idle claim", cmdClaim, 0);
    check("R11 idle ack", ackOut, 0);
    sweepAddr();

    // main sweep: every first byte, hv low then high
    for (int hv = 0; hv < 2; hv++) begin
      for (int b = 0; b < 256; b++) begin
        sendByte(8'(b), 1'b1, hv[0]);
        sendByte(8'h00, 1'b0, hv[0]);
        sendByte(8'h00, 1'b0, hv[0]);
        sendStop();
      end
      sweepAddr();
    end
    check("R3 mask after sweeps", protMask, 4'b0110);

    // R6: one dummy byte only
    sendByte(8'h62, 1'b1, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendStop();
    check("R6 short sequence no commit", protMask, 4'b0110);
    // R6: three dummy bytes (third NACKed)
    sendByte(8'h62, 1'b1, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendStop();
    check("R6 long sequence no commit", protMask, 4'b0110);
    // R7: repeated START drops pending set
    sendByte(8'h60, 1'b1, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendByte(8'h00, 1'b0, 1'b1);
    sendByte(8'hA0, 1'b1, 1'b0);
    sendByte(8'h12, 1'b0, 1'b0);
    sendStop();
    check("R7 repeated START drops set", protMask, 4'b0110);
    // R2 queries reflect mask
    sendByte(8'h61, 1'b1, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendStop();
    sendByte(8'h69, 1'b1, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendStop();
    // R3 set block 3 then R4 clear
    sendByte(8'h60, 1'b1, 1'b1); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendStop();
    check("R3 set block3", protMask, 4'b1110);
    sweepAddr();
    sendByte(8'h66, 1'b1, 1'b1); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendStop();
    check("R4 clear all", protMask, 4'b0000);
    sweepAddr();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule